// File: doc/BRIEF.md
# Metering status and interrupt controller

This block gathers event and condition flags from a three-phase metering core into one 20-bit status word, and it drives an active-low interrupt line. The interrupt line is the masked OR of that word, using a 32-bit mask register. The block also checks that the host keeps up with its work. It flags an interval in which the host read none of the per-phase energy registers. For each of four pulse generators in external-input mode, it flags an interval that brought no update from the host.

The host uses a small register bus to reach the block. Address 0 returns the status word. Address 1 reads or writes the mask. Reading the status word clears the event bits, but the level bits keep showing their current condition. The comparator and the digital-pin inputs are asynchronous, so each passes through a two-flop synchronizer before edge detection. All strobes are single-cycle pulses in the block's clock domain.

Top module: `meter_status_irq`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0 and `irq_n` is high.
- R2: A bus write with `bus_addr`=1 loads all 32 mask bits. A bus read with `bus_addr`=1 returns the mask, and with `bus_addr`=0 returns the status word. Read data appears on `bus_rdata` one cycle after the request.
- R3: Status bit 11 (ready) is set by every `acc_strobe`.
- R4: At an `acc_strobe`, status bit 10 (missed read) is set if none of the `wh_rd` strobes fired since the previous `acc_strobe`. A `wh_rd` strobe in the same cycle as the `acc_strobe` counts toward the closing interval. The first `acc_strobe` after reset never sets bit 10.
- R5: Status bit 8 is set at an `acc_strobe` if the synchronized comparator level changed since the previous `acc_strobe`. Before that strobe, the bit stays clear.
- R6: Status bit 9 is set within a few cycles of a change on any pin whose `pin_sel` bit is 1, without waiting for `acc_strobe`. Changes on unselected pins have no effect.
- R7: Status bit 7 toggles on each `sec_tick` pulse. A status read does not clear it.
- R8: Status bits 12, 13 and 14 hold `creep[0]`, `creep[1]` and `creep[2]` as sampled at the latest `acc_strobe`. A status read does not clear them.
- R9: Status bit 15 is set by a `cmd_rej` pulse.
- R10: At an `acc_strobe`, status bit 16+g is set for each generator g that has `gen_ext[g]`=1 and saw no `gen_upd[g]` since the previous `acc_strobe`. A same-cycle update counts.
- R11: A status read clears bits 8–11 and 15–19, and returns the value from before the clear. An event that sets a bit in the same cycle wins over the clear.
- R12: `irq_n` is low exactly when some status bit has its mask bit set.
- R13: Status reads return 0 in bits 0–6 and 20–31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_strobe | input | 1 | End-of-accumulation-interval pulse |
| sec_tick | input | 1 | One-second pulse |
| cmp_level | input | 1 | Asynchronous comparator level |
| pin_level | input | NPIN | Asynchronous digital pin levels |
| pin_sel | input | NPIN | Per-pin enable for edge reporting |
| creep | input | 3 | Per-phase creep indication (A, B, C) |
| wh_rd | input | 3 | Host read strobes of the per-phase energy registers |
| gen_ext | input | 4 | Per-generator external-input mode |
| gen_upd | input | 4 | Per-generator host update strobes |
| cmd_rej | input | 1 | Host command rejected pulse |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status, 1 = mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong missed-read or update-tracking flag does not show up at once. It shows only at the next interval strobe, as a wrong bit 10 or bits 16–19 in the following status read. So the bench sweeps every read pattern and all 256 mode/update pairs, and reads status after each strobe. A bad clear-on-read or set-priority decision appears on the second of two back-to-back reads. A bad masking path appears on `irq_n` in the same cycle, which the walking-mask sweep catches.

// File: rtl/meter_status_irq.sv
module meter_status_irq #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_strobe,
  input  logic            sec_tick,
  input  logic            cmp_level,
  input  logic [NPIN-1:0] pin_level,
  input  logic [NPIN-1:0] pin_sel,
  input  logic [2:0]      creep,
  input  logic [2:0]      wh_rd,
  input  logic [3:0]      gen_ext,
  input  logic [3:0]      gen_upd,
  input  logic            cmd_rej,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_n
);
  localparam logic [19:0] EVT = 20'hF8F00;

  logic [1:0]      cmp_s;
  logic            cmp_d, cmp_seen;
  logic [NPIN-1:0] pin_s1, pin_s2, pin_d;
  logic            wh_seen, primed, sec_q;
  logic [3:0]      upd_seen;
  logic [2:0]      creep_q;
  logic [19:0]     evt_q, evt_set, status;
  logic [31:0]     mask_q;

  wire rd_stat  = bus_sel & ~bus_wr & ~bus_addr;
  wire wr_mask  = bus_sel & bus_wr & bus_addr;
  wire cmp_edge = cmp_s[1] ^ cmp_d;
  wire pin_edge = |((pin_s2 ^ pin_d) & pin_sel);
  wire wh_any   = wh_seen | (|wh_rd);
  wire [3:0] upd_any = upd_seen | gen_upd;

  always_comb begin
    evt_set        = '0;
    evt_set[8]     = acc_strobe & (cmp_seen | cmp_edge);
    evt_set[9]     = pin_edge;
    evt_set[10]    = acc_strobe & primed & ~wh_any;
    evt_set[11]    = acc_strobe;
    evt_set[15]    = cmd_rej;
    evt_set[19:16] = {4{acc_strobe}} & gen_ext & ~upd_any;
  end

  assign status = evt_q | {5'b0, creep_q, 4'b0, sec_q, 7'b0};
  assign irq_n  = ~|(status & mask_q[19:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_s    <= '0;
      cmp_d    <= 1'b0;
      pin_s1   <= '0;
      pin_s2   <= '0;
      pin_d    <= '0;
      cmp_seen <= 1'b0;
      wh_seen  <= 1'b0;
      primed   <= 1'b0;
      upd_seen <= '0;
      sec_q    <= 1'b0;
      creep_q  <= '0;
      evt_q    <= '0;
      mask_q   <= '0;
      bus_rdata <= '0;
    end else begin
      cmp_s  <= {cmp_s[0], cmp_level};
      cmp_d  <= cmp_s[1];
      pin_s1 <= pin_level;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
      cmp_seen <= acc_strobe ? 1'b0 : (cmp_seen | cmp_edge);
      wh_seen  <= acc_strobe ? 1'b0 : wh_any;
      upd_seen <= acc_strobe ? 4'b0 : upd_any;
      if (acc_strobe) begin
        primed  <= 1'b1;
        creep_q <= creep;
      end
      if (sec_tick) sec_q <= ~sec_q;
      evt_q <= ((rd_stat ? 20'b0 : evt_q) | evt_set) & EVT;
      if (wr_mask) mask_q <= bus_wdata;
      if (bus_sel && !bus_wr)
        bus_rdata <= bus_addr ? mask_q : {12'b0, status};
    end
  end
endmodule

module meter_status_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_strobe,
  input logic        sec_tick,
  input logic [2:0]  creep,
  input logic        cmd_rej,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [19:0] status,
  input logic [31:0] mask_q
);
  wire rd_s = bus_sel & ~bus_wr & ~bus_addr;

  assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr) |=> mask_q == $past(bus_wdata));
  assert_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |=> status[11]);
  assert_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> status[7] != $past(status[7]));
  assert_creep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |=> status[14:12] == $past(creep));
  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rej |=> status[15]);
  assert_generr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !acc_strobe) |=> status[19:16] == 4'b0);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !cmd_rej) |=> !status[15]);
  assert_unused_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_s) |-> (bus_rdata[6:0] == 7'b0 && bus_rdata[31:20] == 12'b0));
endmodule

bind meter_status_irq meter_status_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .sec_tick(sec_tick),
  .creep(creep), .cmd_rej(cmd_rej), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .status(status), .mask_q(mask_q)
);

// File: tb/sim_meter_status_irq.sv
module sim_meter_status_irq;
  logic clk = 0, rst_n = 0;
  logic acc_strobe = 0, sec_tick = 0, cmp_level = 0, cmd_rej = 0;
  logic [7:0] pin_level = '0, pin_sel = '0;
  logic [2:0] creep = '0, wh_rd = '0;
  logic [3:0] gen_ext = '0, gen_upd = '0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  logic [31:0] d, d2;

  always #2 clk = ~clk;

  meter_status_irq #(.NPIN(8)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    acc_strobe = 1; cyc(1); acc_strobe = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = a; cyc(1);
    bus_sel = 0; v = bus_rdata;
  endtask

  task automatic wmask(input logic [31:0] v);
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = v; cyc(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    rd(0, d); chk(d == 0, "R1 status", d, 0);
    rd(1, d); chk(d == 0, "R1 mask", d, 0);
    chk(irq_n == 1, "R1 irq_n", irq_n, 1);

    for (int b = 0; b < 32; b++) begin
      wmask(32'h1 << b); rd(1, d);
      chk(d == (32'h1 << b), "R2 mask walk", d, 32'h1 << b);
    end
    wmask(32'hA5C3_0F96); rd(1, d); chk(d == 32'hA5C3_0F96, "R2 mask pattern", d, 32'hA5C3_0F96);
    wmask(0);

    strobe(); rd(0, d);
    chk(d[11] == 1, "R3 ready", d, 32'h800);
    chk(d[10] == 0, "R4 first interval no overflow", d[10], 0);
    rd(0, d); chk(d[11] == 0, "R11 ready cleared", d[11], 0);

    for (int r = 0; r < 8; r++) begin
      rd(0, d);
      if (r != 0) begin wh_rd = r[2:0]; cyc(1); wh_rd = 0; end
      cyc(2); strobe(); rd(0, d);
      chk(d[10] == (r == 0), "R4 overflow sweep", d[10], (r == 0));
      chk(d[11] == 1, "R3 ready sweep", d[11], 1);
    end
    rd(0, d); wh_rd = 3'b010; strobe(); wh_rd = 0; rd(0, d);
    chk(d[10] == 0, "R4 same-cycle read", d[10], 0);

    for (int e = 0; e < 16; e++)
      for (int u = 0; u < 16; u++) begin
        gen_ext = 0; strobe(); rd(0, d);
        if (u != 0) begin gen_upd = u[3:0]; cyc(1); gen_upd = 0; end
        gen_ext = e[3:0]; strobe(); rd(0, d);
        chk(d[19:16] == (e[3:0] & ~u[3:0]), "R10 generator sweep", d[19:16], e[3:0] & ~u[3:0]);
      end
    gen_ext = 4'hF; strobe(); rd(0, d); gen_upd = 4'h5; strobe(); gen_upd = 0; rd(0, d);
    chk(d[19:16] == 4'hA, "R10 same-cycle update", d[19:16], 4'hA);
    gen_ext = 0;

    for (int c = 0; c < 8; c++) begin
      creep = c[2:0]; strobe(); creep = 0; cyc(1); rd(0, d); rd(0, d2);
      chk(d[14:12] == c[2:0], "R8 creep capture", d[14:12], c);
      chk(d2[14:12] == c[2:0], "R8 creep kept after read", d2[14:12], c);
    end
    strobe(); rd(0, d);

    sec_tick = 1; cyc(1); sec_tick = 0; rd(0, d); rd(0, d2);
    chk(d[7] == 1 && d2[7] == 1, "R7 second toggle on", {d[7], d2[7]}, 2'b11);
    sec_tick = 1; cyc(1); sec_tick = 0; rd(0, d);
    chk(d[7] == 0, "R7 second toggle off", d[7], 0);

    rd(0, d);
    cmp_level = 1; cyc(5); rd(0, d);
    chk(d[8] == 0, "R5 no flag before interval", d[8], 0);
    strobe(); rd(0, d); chk(d[8] == 1, "R5 comparator change", d[8], 1);
    strobe(); rd(0, d); chk(d[8] == 0, "R5 no change interval", d[8], 0);

    pin_sel = 8'b0110_1001;
    for (int p = 0; p < 8; p++) begin
      rd(0, d);
      pin_level[p] = ~pin_level[p]; cyc(5); rd(0, d);
      chk(d[9] == pin_sel[p], "R6 pin edge", d[9], pin_sel[p]);
    end

    rd(0, d);
    cmd_rej = 1; cyc(1); cmd_rej = 0; rd(0, d);
    chk(d[15] == 1, "R9 command rejected", d[15], 1);
    chk(d[6:0] == 0 && d[31:20] == 0, "R13 unused bits", d, d & 32'h000F_FF80);
    cmd_rej = 1; rd(0, d); cmd_rej = 0;
    chk(d[15] == 0, "R11 pre-clear value returned", d[15], 0);
    rd(0, d); chk(d[15] == 1, "R11 set wins over clear", d[15], 1);

    cmd_rej = 1; cyc(1); cmd_rej = 0;
    for (int b = 0; b < 32; b++) begin
      wmask(32'h1 << b); cyc(1);
      chk(irq_n == (b != 15), "R12 irq walking mask", irq_n, (b != 15));
    end
    wmask(32'h8000); rd(0, d); cyc(1);
    chk(irq_n == 1, "R12 irq released by read", irq_n, 1);
    wmask(32'h800); strobe();
    chk(irq_n == 0, "R12 irq on ready", irq_n, 0);
    wmask(0);
    chk(irq_n == 1, "R12 irq masked", irq_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule